// File: doc/BRIEF.md
# Priority-Chained Single-Cycle Mutex

This block is a one-bit hardware lock shared by a set of requesting processes ranked in a fixed order. Each clock cycle, every process may raise a lock request and an unlock request. The answer to a lock request comes back combinationally in the same cycle. The lock itself is a single stored bit that changes only at the rising clock edge.

Lock resolution runs along a one-way chain. The "already taken" condition starts at the stored state and flows from port 0 toward the highest-numbered port. A lower-ranked port therefore never feeds a higher-ranked one, and the chain contains no combinational loop. An unlock frees the lock only from the next cycle. A process that locks and unlocks in the same cycle therefore owns the lock for exactly that one cycle. The status output shows the stored state.

Top module: `prio_mutex`

## Requirements
- R1: A synchronous active-high reset puts the lock in the unlocked state, so `locked` reads 0 after the reset edge, including when the lock was held before the reset.
- R2: While `locked` is 1 at the start of a cycle, every bit of `grant` is 0 in that cycle, whatever the lock requests are.
- R3: Port 0 has the highest priority and rank falls as the index rises. When the lock is free and several ports request it, only the lowest-indexed requester gets its `grant` bit, so at most one `grant` bit is ever 1.
- R4: When `locked` is 0 and any lock request is present, the `grant` bit of the winning port is 1 in that same cycle, with no clock edge between the request and the grant.
- R5: After a grant in a cycle with no unlock request, `locked` is 1 from the next cycle. It stays 1 through cycles with no unlock request, even when further lock requests arrive.
- R6: An unlock request issued while the lock is held does not free the lock within that cycle: lock requests in that cycle still see no grant. `locked` reads 0 from the next cycle.
- R7: A lock and an unlock raised by the same port in the same free cycle give that port the grant for that cycle. `locked` reads 0 in the following cycle, and a new request is granted then.
- R8: An unlock request from any port is honoured, whether or not that port holds the lock. This includes an unlock from another port in the same cycle as a fresh grant, which also leaves the lock free in the next cycle.
- R9: An unlock request while the lock is already free has no effect: `locked` stays 0, and a later lock request is granted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the unlocked state |
| lockReq | input | NUM_PORTS | Per-port lock request; bit 0 has the highest rank |
| unlockReq | input | NUM_PORTS | Per-port unlock request, takes effect at the next edge |
| grant | output | NUM_PORTS | Per-port lock success in the current cycle, combinational |
| locked | output | 1 | Stored lock state, 1 when held |

## Verification
The hardest situations to reach are the cycles where a grant and a release meet at the same edge. One is a lock and an unlock from the same port in one cycle. The other is a grant to one port while a different port unlocks. In both, the lock must be visible as taken within the cycle, yet free at the next edge. The bench forces these cases by driving both request vectors at the falling edge. It reads `grant` before the rising edge and reads `locked` just after it, then offers a new request in the following cycle to show that the lock really is free.

// File: rtl/prio_mutex_pkg.sv
package prio_mutex_pkg;

  // Strobes the grant chain hands to the state control each cycle.
  typedef struct packed {
    logic takeStb;  // some port was granted this cycle
    logic freeStb;  // some port asked for release this cycle
  } mutex_strobe_t;

endpackage

// File: rtl/prio_mutex_chain.sv
module prio_mutex_chain
  import prio_mutex_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 held,
  input  logic [NUM_PORTS-1:0] lockReq,
  input  logic [NUM_PORTS-1:0] unlockReq,
  output logic [NUM_PORTS-1:0] grant,
  output mutex_strobe_t        strobes
);

  // takenRipple[i] is 1 when the lock is unavailable to port i.
  // It flows only toward higher indices (lower rank).
  logic [NUM_PORTS:0] takenRipple;

  assign takenRipple[0] = held;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_link
    assign grant[i]         = lockReq[i] & ~takenRipple[i];
    assign takenRipple[i+1] = takenRipple[i] | lockReq[i];
  end

  always_comb begin
    strobes.takeStb = |grant;
    strobes.freeStb = |unlockReq;
  end

  // R3: never two winners in one cycle
  p_single_winner_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2: a held lock blocks every port
  p_held_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    held |-> (grant == '0));

  // R4: a free lock with any request yields a grant now
  p_free_grants_r4: assert property (@(posedge clk) disable iff (rst)
    (!held && (lockReq != '0)) |-> (grant != '0));

  // R3: a winner has no higher-ranked competitor
  for (genvar i = 1; i < NUM_PORTS; i++) begin : g_rank_chk
    p_rank_order_r3: assert property (@(posedge clk) disable iff (rst)
      grant[i] |-> (lockReq[i-1:0] == '0));
  end

endmodule

// File: rtl/prio_mutex_ctrl.sv
module prio_mutex_ctrl
  import prio_mutex_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  mutex_strobe_t strobes,
  output logic          held
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
    end else begin
      held <= (held | strobes.takeStb) & ~strobes.freeStb;
    end
  end

  // R6: a release always lands at the next edge
  p_release_next_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.freeStb |=> !held);

  // R9: no request and free stays free
  p_idle_free_r9: assert property (@(posedge clk) disable iff (rst)
    (!held && !strobes.takeStb) |=> !held);

endmodule

// File: rtl/prio_mutex.sv
module prio_mutex
  import prio_mutex_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] lockReq,
  input  logic [NUM_PORTS-1:0] unlockReq,
  output logic [NUM_PORTS-1:0] grant,
  output logic                 locked
);

  mutex_strobe_t strobes;
  logic          held;

  prio_mutex_chain #(.NUM_PORTS(NUM_PORTS)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .held     (held),
    .lockReq  (lockReq),
    .unlockReq(unlockReq),
    .grant    (grant),
    .strobes  (strobes)
  );

  prio_mutex_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .held   (held)
  );

  assign locked = held;

  // R5: a grant with no unlock leaves the lock held next cycle
  p_grant_holds_r5: assert property (@(posedge clk) disable iff (rst)
    ((grant != '0) && (unlockReq == '0)) |=> locked);

  // R5: held with no unlock remains held
  p_hold_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (locked && (unlockReq == '0)) |=> locked);

  // R8: an unlock from any port frees the lock next cycle
  p_any_unlock_r8: assert property (@(posedge clk) disable iff (rst)
    (unlockReq != '0) |=> !locked);

  // R1: reset edge leaves the lock free
  p_reset_free_r1: assert property (@(posedge clk)
    rst |=> !locked);

endmodule

// File: tb/prio_mutex_bench.sv
`timescale 1ns/1ps
module prio_mutex_bench;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] lockReq = '0;
  logic [NP-1:0] unlockReq = '0;
  logic [NP-1:0] grant;
  logic          locked;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_mutex #(.NUM_PORTS(NP)) u_prio_mutex (
    .clk      (clk),
    .rst      (rst),
    .lockReq  (lockReq),
    .unlockReq(unlockReq),
    .grant    (grant),
    .locked   (locked)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, check grant in the same cycle,
  // then check the stored state just after the next rising edge.
  task automatic step(input logic [NP-1:0] lk, input logic [NP-1:0] ul,
                      input logic [NP-1:0] expGrant, input logic expLocked,
                      input string tag);
    @(negedge clk);
    lockReq   = lk;
    unlockReq = ul;
    #1;
    check({tag, " grant"}, int'(grant), int'(expGrant));
    @(posedge clk);
    #1;
    check({tag, " locked"}, int'(locked), int'(expLocked));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", int'(locked), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle grant", int'(grant), 0);
  endtask

  task automatic t_basic();
    step(4'b0001, 4'b0000, 4'b0001, 1'b1, "R4 same-cycle grant");
    step(4'b0000, 4'b0000, 4'b0000, 1'b1, "R5 hold idle");
    step(4'b1111, 4'b0000, 4'b0000, 1'b1, "R2 all blocked");
    step(4'b0010, 4'b0001, 4'b0000, 1'b0, "R6 unlock not yet visible");
    step(4'b0010, 4'b0000, 4'b0010, 1'b1, "R6 free next cycle");
    step(4'b0000, 4'b1000, 4'b0000, 1'b0, "R8 unlock by non-holder");
  endtask

  task automatic t_priority();
    step(4'b1110, 4'b0000, 4'b0010, 1'b1, "R3 lowest index wins");
    step(4'b0001, 4'b0010, 4'b0000, 1'b0, "R2 port0 blocked while held");
    step(4'b1100, 4'b0000, 4'b0100, 1'b1, "R3 pick port2");
    step(4'b0000, 4'b0100, 4'b0000, 1'b0, "R6 release");
    step(4'b0101, 4'b0000, 4'b0001, 1'b1, "R3 pick port0");
    step(4'b0000, 4'b0001, 4'b0000, 1'b0, "R6 release again");
    step(4'b1000, 4'b0000, 4'b1000, 1'b1, "R4 lone lowest rank");
    step(4'b0000, 4'b1000, 4'b0000, 1'b0, "R6 release last");
  endtask

  task automatic t_same_cycle();
    step(4'b0100, 4'b0100, 4'b0100, 1'b0, "R7 lock and unlock");
    step(4'b0001, 4'b0000, 4'b0001, 1'b1, "R7 free following cycle");
    step(4'b0000, 4'b0001, 4'b0000, 1'b0, "R7 cleanup");
    step(4'b0001, 4'b1000, 4'b0001, 1'b0, "R8 grant with foreign unlock");
    step(4'b0100, 4'b0000, 4'b0100, 1'b1, "R8 free after foreign unlock");
    step(4'b0000, 4'b0001, 4'b0000, 1'b0, "R8 unlock by other port");
  endtask

  task automatic t_idle_unlock();
    step(4'b0000, 4'b1111, 4'b0000, 1'b0, "R9 unlock when free");
    step(4'b0000, 4'b0010, 4'b0000, 1'b0, "R9 unlock when free again");
    step(4'b0010, 4'b0000, 4'b0010, 1'b1, "R9 later lock normal");
  endtask

  task automatic t_reset_while_held();
    @(negedge clk);
    lockReq   = '0;
    unlockReq = '0;
    check("R1 held before reset", int'(locked), 1);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset frees lock", int'(locked), 0);
    @(negedge clk);
    rst = 1'b0;
    step(4'b1000, 4'b0000, 4'b1000, 1'b1, "R1 usable after reset");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_priority();
    t_same_cycle();
    t_idle_unlock();
    t_reset_while_held();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule